// File: doc/BRIEF.md
# Supervisory Reset Generator

This block merges five fault requests into stretched reset outputs. Two supply-undervoltage flags, an auxiliary-threshold flag, a manual reset pin and a watchdog-expiry pulse all feed it. The three flags are active-low and already synchronised to the clock. Any active request pulls the primary reset low at once. The reset stays low until every request has cleared and one timeout period has elapsed since then.

A second active-low reset listens only to the supplies and the manual pin. An active-high copy of the primary reset is also provided. A power-fail flag passes straight through with no stretching. The timeout is counted in ticks of an external millisecond enable, or of a 100 us enable for the shortest code, and a 3-bit code selects its length. The manual pin is synchronised and glitch-filtered before use. A one-cycle event pulse marks each fresh assertion of the primary reset, so that a watchdog can clear itself on it.

Top module: `supv_reset_gen`

## Requirements
- R1: The edge after `sup_a_ni`, `sup_b_ni` or `aux_ni` is low, after `wdt_exp_i` is high, or after the filtered manual pin is low, `rst_no` is 0.
- R2: Once no request is active, `rst_no` stays 0 for exactly the selected number of timeout ticks. With the tick high every cycle, it reads 1 after that many clock edges. A one-cycle `wdt_exp_i` pulse gives exactly one period.
- R3: A request that reappears during the timeout clears the count, and the full period runs again from its release.
- R4: A manual reset holds `rst_no` at 0 while the pin is low. After release it adds 2 synchroniser edges, MR_FILT_CYC filter edges and then one full period (158 edges with the defaults and code 3).
- R5: A manual low pulse shorter than MR_FILT_CYC clocks (default 16, i.e. 128 ns) has no effect. A pulse of MR_FILT_CYC clocks or more asserts reset.
- R6: `tmo_code_i` sets the period. Code 1 gives 11 ticks of `tick_100us_i`. With `tick_ms_i` as the tick, code 2 gives 9, code 3 gives 140, code 5 gives 280, code 6 gives 560, and codes 4, 0 and 7 give 1120.
- R7: `rst2_no` is driven only by the two supply flags and the manual pin. `aux_ni` and `wdt_exp_i` leave it at 1.
- R8: `rst_o` is always the complement of `rst_no`.
- R9: `pf_no` follows `pf_ni` in the same cycle and does not touch the reset outputs.
- R10: While `rst_ni` is low, `rst_no` and `rst2_no` are 0, `rst_o` is 1 and `rst_evt_o` is 0. After release, a full period runs before `rst_no` rises.
- R11: `rst_evt_o` pulses for one cycle, in the cycle in which `rst_no` goes from 1 to 0. It does not pulse at power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_ms_i | input | 1 | Millisecond tick enable |
| tick_100us_i | input | 1 | 100 us tick enable for code 1 |
| tmo_code_i | input | 3 | Timeout length code |
| sup_a_ni | input | 1 | Primary supply below threshold when 0 |
| sup_b_ni | input | 1 | Secondary supply below threshold when 0 |
| aux_ni | input | 1 | Auxiliary input below threshold when 0 |
| mr_ni | input | 1 | Manual reset pin, asynchronous, active low |
| wdt_exp_i | input | 1 | Watchdog expiry pulse |
| pf_ni | input | 1 | Power-fail flag, active low |
| rst_no | output | 1 | Primary reset, active low |
| rst_o | output | 1 | Primary reset, active high |
| rst2_no | output | 1 | Secondary reset, active low |
| pf_no | output | 1 | Power-fail output, active low |
| rst_evt_o | output | 1 | One-cycle pulse on a new primary assertion |

## Verification
Two things can fall in the same cycle: the timeout counter taking a tick and a request re-asserting. The bench releases a supply flag, lets the count run for a few ticks, then drops the flag again for a single cycle. The check passes only if the release edge measured afterwards equals a full period, which shows the counter cleared and did not carry on. A watchdog pulse that lands while both resets are idle is a second collision. There the event pulse and the secondary output are judged in the same episode: exactly one event, and `rst2_no` never low.

// File: rtl/supv_reset_pkg.sv
package supv_reset_pkg;
  typedef logic [2:0] tmo_code_t;
  localparam tmo_code_t TMO_FINE = 3'd1;
  localparam tmo_code_t TMO_9    = 3'd2;
  localparam tmo_code_t TMO_140  = 3'd3;
  localparam tmo_code_t TMO_280  = 3'd5;
  localparam tmo_code_t TMO_560  = 3'd6;
  localparam int NUM_RST = 2;
endpackage

// File: rtl/mr_filter.sv
module mr_filter #(
  parameter int FILT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic press_o
);
  localparam int CNTW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

  logic [1:0]      sync_q;
  logic            state_q;  // filtered pin level, 1 = released
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      state_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_ni};
      if (sync_q[1] != state_q) begin
        if (cnt_q == CNTW'(FILT_CYC - 1)) begin
          state_q <= sync_q[1];
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign press_o = ~state_q;

  // R5
  mr_press_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(state_q) |-> !$past(sync_q[1]));
endmodule

// File: rtl/reset_timer.sv
module reset_timer
  import supv_reset_pkg::*;
#(
  parameter int P_FINE = 11,
  parameter int P_9    = 9,
  parameter int P_140  = 140,
  parameter int P_280  = 280,
  parameter int P_560  = 560,
  parameter int P_LONG = 1120,
  parameter int CW     = 11
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hold_i,
  input  logic      tick_ms_i,
  input  logic      tick_fine_i,
  input  tmo_code_t code_i,
  output logic      active_o
);
  logic [CW-1:0] period, cnt_q;
  logic          fine_sel, tick;
  logic          active_q;

  always_comb begin
    fine_sel = 1'b0;
    case (code_i)
      TMO_FINE: begin period = CW'(P_FINE); fine_sel = 1'b1; end
      TMO_9:    period = CW'(P_9);
      TMO_140:  period = CW'(P_140);
      TMO_280:  period = CW'(P_280);
      TMO_560:  period = CW'(P_560);
      default:  period = CW'(P_LONG);  // code 4 and unused codes
    endcase
  end

  assign tick = fine_sel ? tick_fine_i : tick_ms_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (hold_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick) begin
      if (cnt_q == period - 1'b1) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;

  // R1
  hold_asserts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> active_o);
  // R3
  hold_restarts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));
  // R2
  release_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> ($past(tick) && !$past(hold_i)));
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_reset_pkg::*;
#(
  parameter int MR_FILT_CYC = 16,
  parameter int P_FINE      = 11,
  parameter int P_9         = 9,
  parameter int P_140       = 140,
  parameter int P_280       = 280,
  parameter int P_560       = 560,
  parameter int P_LONG      = 1120
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_ms_i,
  input  logic       tick_100us_i,
  input  logic [2:0] tmo_code_i,
  input  logic       sup_a_ni,
  input  logic       sup_b_ni,
  input  logic       aux_ni,
  input  logic       mr_ni,
  input  logic       wdt_exp_i,
  input  logic       pf_ni,
  output logic       rst_no,
  output logic       rst_o,
  output logic       rst2_no,
  output logic       pf_no,
  output logic       rst_evt_o
);
  localparam int CW = $clog2(P_LONG + 1);

  logic               mr_press;
  logic               sup_fault;
  logic [NUM_RST-1:0] hold, active;
  logic               evt_q;

  mr_filter #(.FILT_CYC(MR_FILT_CYC)) u_mr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (mr_ni),
    .press_o(mr_press)
  );

  assign sup_fault = ~sup_a_ni | ~sup_b_ni | mr_press;
  assign hold[0]   = sup_fault | ~aux_ni | wdt_exp_i;
  assign hold[1]   = sup_fault;

  for (genvar g = 0; g < NUM_RST; g++) begin : g_tmr
    reset_timer #(
      .P_FINE(P_FINE), .P_9(P_9), .P_140(P_140), .P_280(P_280),
      .P_560(P_560), .P_LONG(P_LONG), .CW(CW)
    ) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hold_i     (hold[g]),
      .tick_ms_i  (tick_ms_i),
      .tick_fine_i(tick_100us_i),
      .code_i     (tmo_code_i),
      .active_o   (active[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= hold[0] & ~active[0];
  end

  assign rst_no    = ~active[0];
  assign rst_o     = active[0];
  assign rst2_no   = ~active[1];
  assign pf_no     = pf_ni;
  assign rst_evt_o = evt_q;

  // R7
  rst2_sources_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst2_no) |-> $past(!sup_a_ni || !sup_b_ni || mr_press));
  // R11
  evt_on_new_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_evt_o |-> (!rst_no && $past(rst_no)));
  // R8
  rst_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $fell(rst_o));
endmodule

// File: tb/supv_reset_gen_test.sv
module supv_reset_gen_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_ms = 1'b1, tick_fine = 1'b0;
  logic [2:0] code = 3'd3;
  logic sup_a = 1'b1, sup_b = 1'b1, aux = 1'b1, mr = 1'b1, wdt = 1'b0, pf = 1'b1;
  logic rst_no, rst_o, rst2_no, pf_no, rst_evt_o;

  int checks = 0, fails = 0;
  int evt_cnt = 0, r2_low = 0, comp_err = 0;

  localparam int FILT = 16;

  always #4 clk = ~clk;  // 125 MHz

  supv_reset_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_ms_i(tick_ms), .tick_100us_i(tick_fine),
    .tmo_code_i(code), .sup_a_ni(sup_a), .sup_b_ni(sup_b), .aux_ni(aux),
    .mr_ni(mr), .wdt_exp_i(wdt), .pf_ni(pf), .rst_no(rst_no), .rst_o(rst_o),
    .rst2_no(rst2_no), .pf_no(pf_no), .rst_evt_o(rst_evt_o)
  );

  // {src[1:0], code[2:0], expected ticks[10:0]}; src 0 sup_a, 1 sup_b, 2 aux, 3 wdt
  localparam logic [15:0] VEC [8] = '{
    {2'd0, 3'd3, 11'd140}, {2'd1, 3'd1, 11'd11},  {2'd2, 3'd2, 11'd9},
    {2'd3, 3'd5, 11'd280}, {2'd0, 3'd6, 11'd560}, {2'd2, 3'd4, 11'd1120},
    {2'd3, 3'd0, 11'd1120}, {2'd1, 3'd7, 11'd1120}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (rst_evt_o) evt_cnt++;
    if (!rst2_no) r2_low++;
    if (rst_o == rst_no) comp_err++;
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!rst_no && n < 3000);
  endtask

  task automatic clear_cnt();
    evt_cnt = 0; r2_low = 0; comp_err = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [1:0] src;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(rst_no == 1'b0, "R10 rst_no in reset", rst_no, 0);
    chk(rst2_no == 1'b0, "R10 rst2_no in reset", rst2_no, 0);
    chk(rst_o == 1'b1 && rst_evt_o == 1'b0, "R10 rst_o/evt in reset", {rst_o, rst_evt_o}, 2);
    clear_cnt();
    rst_ni = 1'b1;
    measure(n);
    chk(n == 140, "R10 power-on period", n, 140);
    chk(evt_cnt == 0, "R11 no event at power-on", evt_cnt, 0);
    chk(rst2_no == 1'b1, "R10 rst2_no released", rst2_no, 1);

    // table walk: R1 R2 R6 R7 R8 R11
    for (int i = 0; i < 8; i++) begin
      src  = VEC[i][15:14];
      code = VEC[i][13:11];
      tick_ms   = (VEC[i][13:11] != 3'd1);
      tick_fine = (VEC[i][13:11] == 3'd1);
      step();
      clear_cnt();
      case (src)
        2'd0: sup_a = 1'b0;
        2'd1: sup_b = 1'b0;
        2'd2: aux = 1'b0;
        default: wdt = 1'b1;
      endcase
      step();
      chk(rst_no == 1'b0, "R1 source asserts rst_no", rst_no, 0);
      if (src != 2'd3) begin step(); step(); end
      sup_a = 1'b1; sup_b = 1'b1; aux = 1'b1; wdt = 1'b0;
      measure(n);
      chk(n == int'(VEC[i][10:0]), "R6/R2 period for code", n, int'(VEC[i][10:0]));
      chk(evt_cnt == 1, "R11 one event per assertion", evt_cnt, 1);
      chk(comp_err == 0, "R8 rst_o complement", comp_err, 0);
      if (src >= 2'd2)
        chk(r2_low == 0, "R7 rst2_no ignores aux/wdt", r2_low, 0);
      else
        chk(r2_low > 0 && rst2_no, "R7 rst2_no follows supply", r2_low, 1);
    end

    // R3 restart during timeout
    code = 3'd3; tick_ms = 1'b1; tick_fine = 1'b0;
    step();
    sup_a = 1'b0; step(); sup_a = 1'b1;
    repeat (5) step();
    chk(rst_no == 1'b0, "R3 still in timeout", rst_no, 0);
    sup_a = 1'b0; step(); sup_a = 1'b1;
    measure(n);
    chk(n == 140, "R3 full period after restart", n, 140);

    // R4 manual reset hold and release
    clear_cnt();
    mr = 1'b0;
    repeat (40) step();
    chk(rst_no == 1'b0 && rst2_no == 1'b0, "R4 held while pin low", {rst_no, rst2_no}, 0);
    mr = 1'b1;
    measure(n);
    chk(n == FILT + 2 + 140, "R4 release delay", n, FILT + 2 + 140);

    // R5 glitch rejected, long pulse honoured
    clear_cnt();
    mr = 1'b0; repeat (12) step(); mr = 1'b1;
    repeat (40) step();
    chk(evt_cnt == 0 && rst_no == 1'b1, "R5 short pulse ignored", evt_cnt, 0);
    mr = 1'b0; repeat (FILT) step(); mr = 1'b1;
    repeat (6) step();
    chk(rst_no == 1'b0, "R5 long pulse honoured", rst_no, 0);
    measure(n);
    chk(rst_no == 1'b1, "R5 released after period", rst_no, 1);

    // R9 power-fail pass-through
    pf = 1'b0; #1;
    chk(pf_no == 1'b0, "R9 pf_no follows low", pf_no, 0);
    step();
    chk(rst_no == 1'b1 && rst2_no == 1'b1, "R9 no reset from pf", {rst_no, rst2_no}, 3);
    pf = 1'b1; #1;
    chk(pf_no == 1'b1, "R9 pf_no releases at once", pf_no, 1);

    // R10 reset mid-run
    @(negedge clk); rst_ni = 1'b0; #1;
    chk(rst_no == 1'b0 && rst2_no == 1'b0, "R10 async reset", {rst_no, rst2_no}, 0);
    @(negedge clk); rst_ni = 1'b1;
    measure(n);
    chk(n == 140, "R10 period after reset", n, 140);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule